// File: doc/BRIEF.md
# Pulse Accumulator with Timer Clock Selection

This block counts rising edges on an external pulse input in a 16-bit accumulator. It also decides when a free-running timer counter elsewhere in the chip advances. The timer can step on the prescaler tick, on every accumulator edge, on every 256th edge or on every 65536th edge. The choice is made by a two-bit select field. The block gives one single-cycle enable to the timer counter; it does not drive a derived clock.

Two sticky flags record events. One records an accumulator wrap and the other records an input edge. Each flag has its own interrupt enable and clears on a write of one. A fast-clear option clears both flags whenever software reads or writes the count. Software reaches all of this through a byte-wide synchronous register port with four addresses:

| Address | Contents |
|---|---|
| 0 | control |
| 1 | flags |
| 2 | count high byte |
| 3 | count low byte |

Top module: `pacc_clksel`

## Requirements
- R1: While the accumulator is enabled (control bit 0 = 1), control bits 2:1 choose the source of `tcnt_en`:
  - 00 gives `tick_pre`.
  - 01 gives every accumulator edge.
  - 10 gives the edge on which the free-running edge divider's low 8 bits are all ones.
  - 11 gives the edge on which all 16 divider bits are ones.
- R2: While control bit 0 is 0, `tcnt_en` equals `tick_pre` whatever bits 2:1 hold. In that state edges change neither the count nor the edge flag.
- R3: A new select value governs `tcnt_en` from the cycle right after the write, with no extra delay.
- R4: A rising edge on `pa_in` while enabled and with the count at 0xFFFF sets the overflow flag. On that same edge the count wraps to 0x0000.
- R5: A write to address 1 with bit 1 set clears the overflow flag. A write with bit 1 at 0 leaves it unchanged.
- R6: Address 1 reads the overflow flag at bit 1 and the edge flag at bit 0, with bits 7:2 at zero. All four addresses read 0x00 after reset.
- R7: With control bit 5 set, any read or write of address 2 or 3 clears both flags.
- R8: `ovf_irq` is 1 only when control bit 3 and the overflow flag are both 1. `edge_irq` is 1 only when control bit 4 and the edge flag are both 1.
- R9: Each rising edge on `pa_in` while enabled adds one to the count and sets the edge flag. A write to address 1 with bit 0 set clears the edge flag.
- R10: Under select 10, `tcnt_en` pulses exactly once per 256 enabled edges. Under select 11, it pulses exactly once per 65536 enabled edges. Each pulse lasts one cycle.
- R11: When a flag's set event and a clear of that flag fall in the same cycle, the flag ends up set.
- R12: Address 2 holds count bits 15:8 and address 3 holds bits 7:0. Both can be written and read back. A write to the count takes priority over an edge in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pa_in | input | 1 | Pulse input, synchronous to clk; rising edges are counted |
| tick_pre | input | 1 | Prescaler tick for the timer counter |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address |
| tcnt_en | output | 1 | Single-cycle timer counter advance enable |
| ovf_irq | output | 1 | Overflow interrupt request |
| edge_irq | output | 1 | Input-edge interrupt request |

## Verification
The hardest case to reach from the ports is the pulse on select 11. It needs the free-running divider to pass all ones, and software cannot load or clear that divider. The stimulus therefore sends 65536 back-to-back pulses, one every two cycles. It counts timer enables in both phases of every pulse and expects exactly one. The set-over-clear case is reached by preloading the count to 0xFFFF and raising `pa_in` in the same cycle as a flag write of 0x03.

// File: rtl/pacc_clksel.sv
module pacc_clksel #(
  parameter int CNT_W  = 16,
  parameter int DIV_LO = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pa_in,
  input  logic       tick_pre,
  input  logic       bus_sel,
  input  logic       bus_wr,
  input  logic [1:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       tcnt_en,
  output logic       ovf_irq,
  output logic       edge_irq
);
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_FLAG = 2'd1;
  localparam logic [1:0] A_CHI  = 2'd2;
  localparam logic [1:0] A_CLO  = 2'd3;
  localparam logic [CNT_W-1:0]  CNT_MAX = '1;
  localparam logic [DIV_LO-1:0] LO_MAX  = '1;

  logic [5:0]       ctrl;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] div;
  logic             pa_q;
  logic             ovf_f, edge_f;

  wire en      = ctrl[0];
  wire [1:0] sel = ctrl[2:1];
  wire ovf_ie  = ctrl[3];
  wire edge_ie = ctrl[4];
  wire fast    = ctrl[5];

  wire wr      = bus_sel & bus_wr;
  wire ctrl_wr = wr & (bus_addr == A_CTRL);
  wire flag_wr = wr & (bus_addr == A_FLAG);
  wire chi_wr  = wr & (bus_addr == A_CHI);
  wire clo_wr  = wr & (bus_addr == A_CLO);
  wire cnt_wr  = chi_wr | clo_wr;
  wire cnt_acc = bus_sel & bus_addr[1];

  wire edge_ev = en & pa_in & ~pa_q;
  wire ovf_ev  = edge_ev & ~cnt_wr & (cnt == CNT_MAX);
  wire slow_lo = edge_ev & (div[DIV_LO-1:0] == LO_MAX);
  wire slow_hi = edge_ev & (div == CNT_MAX);

  wire clr_all  = fast & cnt_acc;
  wire clr_ovf  = (flag_wr & bus_wdata[1]) | clr_all;
  wire clr_edge = (flag_wr & bus_wdata[0]) | clr_all;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl   <= '0;
      cnt    <= '0;
      div    <= '0;
      pa_q   <= 1'b0;
      ovf_f  <= 1'b0;
      edge_f <= 1'b0;
    end else begin
      pa_q <= pa_in;
      if (ctrl_wr) ctrl <= bus_wdata[5:0];
      if (edge_ev) div <= div + 1'b1;
      if (chi_wr)       cnt[CNT_W-1:8] <= bus_wdata[CNT_W-9:0];
      else if (clo_wr)  cnt[7:0]       <= bus_wdata;
      else if (edge_ev) cnt            <= cnt + 1'b1;
      if (ovf_ev)        ovf_f <= 1'b1;
      else if (clr_ovf)  ovf_f <= 1'b0;
      if (edge_ev)       edge_f <= 1'b1;
      else if (clr_edge) edge_f <= 1'b0;
    end
  end

  always_comb begin
    if (!en) tcnt_en = tick_pre;
    else begin
      case (sel)
        2'b00:   tcnt_en = tick_pre;
        2'b01:   tcnt_en = edge_ev;
        2'b10:   tcnt_en = slow_lo;
        default: tcnt_en = slow_hi;
      endcase
    end
  end

  always_comb begin
    case (bus_addr)
      A_CTRL:  bus_rdata = {2'b00, ctrl};
      A_FLAG:  bus_rdata = {6'b0, ovf_f, edge_f};
      A_CHI:   bus_rdata = cnt[CNT_W-1:8];
      default: bus_rdata = cnt[7:0];
    endcase
  end

  assign ovf_irq  = ovf_ie & ovf_f;
  assign edge_irq = edge_ie & edge_f;
endmodule

// File: rtl/pacc_clksel_chk.sv
module pacc_clksel_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        en,
  input logic        edge_ev,
  input logic        cnt_wr,
  input logic        cnt_acc,
  input logic        fast,
  input logic        ovf_ie,
  input logic [15:0] cnt,
  input logic        ovf_f,
  input logic        edge_f,
  input logic        tick_pre,
  input logic        tcnt_en,
  input logic        ovf_irq,
  input logic [1:0]  bus_addr,
  input logic [7:0]  bus_rdata
);
  a_r2_disabled_uses_pre: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> tcnt_en == tick_pre);
  a_r4_wrap_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_ev && !cnt_wr && cnt == 16'hFFFF) |=> (ovf_f && cnt == 16'h0000));
  a_r9_edge_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    edge_ev |=> edge_f);
  a_r7_fast_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (fast && cnt_acc && !edge_ev) |=> (!ovf_f && !edge_f));
  a_r6_flag_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    bus_addr == 2'd1 |-> bus_rdata[7:2] == 6'b0);
  a_r8_ovf_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !ovf_ie |-> !ovf_irq);
endmodule

bind pacc_clksel pacc_clksel_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .edge_ev(edge_ev), .cnt_wr(cnt_wr),
  .cnt_acc(cnt_acc), .fast(fast), .ovf_ie(ovf_ie), .cnt(cnt), .ovf_f(ovf_f),
  .edge_f(edge_f), .tick_pre(tick_pre), .tcnt_en(tcnt_en), .ovf_irq(ovf_irq),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata)
);

// File: tb/pacc_clksel_bench.sv
module pacc_clksel_bench;
  localparam int CLK_PERIOD = 10;
  logic clk = 0, rst_n = 0, pa_in = 0, tick_pre = 0;
  logic bus_sel = 0, bus_wr = 0;
  logic [1:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0;
  logic [7:0] bus_rdata;
  logic tcnt_en, ovf_irq, edge_irq;
  int total = 0, bad = 0, ticks = 0;
  logic [7:0] rv;

  pacc_clksel u_pacc_clksel (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk); bus_sel = 0;
  endtask

  task automatic pulse();
    @(negedge clk); pa_in = 1; #1 ticks += int'(tcnt_en);
    @(negedge clk); pa_in = 0; #1 ticks += int'(tcnt_en);
  endtask

  task automatic t_reset();
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], rv); chk("R6 reset read", rv, 0);
    end
    chk("R8 reset irq", {ovf_irq, edge_irq}, 0);
  endtask

  task automatic t_count();
    wr(0, 8'h03);
    ticks = 0;
    repeat (5) pulse();
    chk("R1 sel01 one tick per edge", ticks, 5);
    rd(3, rv); chk("R12 count low", rv, 5);
    rd(2, rv); chk("R12 count high", rv, 0);
    rd(1, rv); chk("R9 edge flag", rv, 8'h01);
    wr(1, 8'h01);
    rd(1, rv); chk("R9 edge flag cleared", rv, 0);
    wr(3, 8'hA5); wr(2, 8'h3C);
    rd(3, rv); chk("R12 write low", rv, 8'hA5);
    rd(2, rv); chk("R12 write high", rv, 8'h3C);
  endtask

  task automatic t_disabled();
    wr(3, 0); wr(2, 0);
    wr(0, 8'h02);
    repeat (3) pulse();
    rd(3, rv); chk("R2 disabled no count", rv, 0);
    rd(1, rv); chk("R2 disabled no edge flag", rv, 0);
    @(negedge clk); tick_pre = 1; #1 chk("R2 disabled follows pre", tcnt_en, 1);
    @(negedge clk); tick_pre = 0; #1 chk("R2 disabled pre low", tcnt_en, 0);
  endtask

  task automatic t_select();
    wr(0, 8'h03);
    @(negedge clk); tick_pre = 1; #1 chk("R1 sel01 ignores pre", tcnt_en, 0);
    tick_pre = 0;
    wr(0, 8'h01);
    tick_pre = 1; #1 chk("R3 sel00 immediate", tcnt_en, 1);
    @(negedge clk); tick_pre = 0;
    ticks = 0; pulse();
    chk("R1 sel00 edge gives no tick", ticks, 0);
  endtask

  task automatic t_ovf();
    wr(0, 8'h01); wr(1, 8'h03);
    wr(3, 8'hFE); wr(2, 8'hFF);
    pulse();
    rd(1, rv); chk("R4 no overflow at FFFF", rv, 8'h01);
    pulse();
    rd(1, rv); chk("R4 overflow flag set", rv, 8'h03);
    rd(3, rv); chk("R4 wrap low", rv, 0);
    rd(2, rv); chk("R4 wrap high", rv, 0);
    chk("R8 irq disabled", {ovf_irq, edge_irq}, 0);
    wr(0, 8'h19);
    chk("R8 both irq", {ovf_irq, edge_irq}, 2'b11);
    wr(1, 8'h01);
    rd(1, rv); chk("R5 zero bit leaves overflow", rv, 8'h02);
    chk("R8 edge irq drops", {ovf_irq, edge_irq}, 2'b10);
    wr(1, 8'h02);
    rd(1, rv); chk("R5 overflow cleared", rv, 0);
    chk("R8 ovf irq drops", ovf_irq, 0);
  endtask

  task automatic t_fast();
    wr(0, 8'h21);
    wr(3, 8'hFF); wr(2, 8'hFF);
    pulse();
    rd(1, rv); chk("R7 flags set before", rv, 8'h03);
    rd(3, rv);
    rd(1, rv); chk("R7 read clears", rv, 0);
    pulse();
    wr(2, 8'h00);
    rd(1, rv); chk("R7 write clears", rv, 0);
    wr(0, 8'h01);
    pulse();
    rd(3, rv);
    rd(1, rv); chk("R7 off keeps flag", rv, 8'h01);
  endtask

  task automatic t_setwins();
    wr(0, 8'h01);
    wr(3, 8'hFF); wr(2, 8'hFF);
    @(negedge clk); pa_in = 1; bus_sel = 1; bus_wr = 1; bus_addr = 1; bus_wdata = 8'h03;
    @(negedge clk); pa_in = 0; bus_sel = 0; bus_wr = 0;
    rd(1, rv); chk("R11 set wins", rv, 8'h03);
    wr(1, 8'h03);
  endtask

  task automatic t_div();
    wr(0, 8'h05);
    ticks = 0;
    repeat (512) pulse();
    chk("R10 div256 two ticks", ticks, 2);
    wr(0, 8'h07);
    ticks = 0;
    repeat (65536) pulse();
    chk("R10 div65536 one tick", ticks, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_count();
    t_disabled();
    t_select();
    t_ovf();
    t_fast();
    t_setwins();
    t_div();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 190000);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule